// File: doc/BRIEF.md
# UART Receive/Transmit FIFO and Interrupt Controller

This block sits between the serial shifters of a 16550-style UART and its register port. Characters arriving from the receive shifter are queued in a receive FIFO, and bytes written by the host are queued in a transmit FIFO for the transmit shifter to take. The block also owns a FIFO control register, an interrupt enable register, an interrupt identification register and a line status register. From these it produces one prioritised interrupt line.

The host reaches the block through a plain read/write strobe port with a 3-bit register offset. Reads return data combinationally for the offset on the bus. A read's side effects (popping the receive FIFO, clearing flags) take place at the clock edge on which the read strobe is high. The receive trigger depth comes from a small fixed set of non-uniform levels. The pending source is reported as an encoded identification code.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset both FIFOs are empty and disabled and the enable register is 0. Register offsets: 0 is data (read pops receive, write pushes transmit), 1 is interrupt enable, 2 is identification on read and FIFO control on write, 5 is line status. After reset the identification register reads 0x01, line status reads 0x20, irq_o is low, and other offsets read 0.
- R2: FIFO control bit 0 enables the FIFOs. While it is 0, each FIFO holds a single entry and the trigger depth is 1. Identification bits 7:6 both equal the enable bit. Any write that changes the enable bit flushes both FIFOs.
- R3: With FIFOs enabled each FIFO holds 16 entries in arrival order. A received character pushed while the receive FIFO is full is dropped and sets line status bit 1. A data write while the transmit FIFO is full is dropped.
- R4: FIFO control bit 1 flushes the receive FIFO and bit 2 flushes the transmit FIFO; both may be set in one write. These bits act only on the write that carries them: a later control write without them keeps FIFO contents.
- R5: FIFO control bits 7:6 select a receive trigger depth of 1, 4, 8 or 14 for codes 0 to 3. The receive-data condition is true exactly while the receive count is at or above that depth.
- R6: Interrupt enable bit 0 gates receive data, bit 1 gates transmit-holding-empty and bit 2 gates receive line status. A source whose bit is 0 is never reported. Bits 2:0 read back at offset 1.
- R7: Identification bit 0 is 0 while any enabled source is pending and 1 otherwise. Bits 3:1 hold 3 for line status, 2 for receive data and 1 for transmit-holding-empty, with that priority order, and 0 when nothing is pending.
- R8: The transmit-holding-empty flag is set when the transmit FIFO goes from non-empty to empty, or when enable bit 1 is written from 0 to 1 while the transmit FIFO is empty. It is cleared by any data write, or by an identification read that shows code 1. If a set and a clear fall in the same cycle, the set wins.
- R9: Line status bit 0 is 1 while the receive FIFO is not empty, and bit 5 is 1 while the transmit FIFO is empty. Bit 2 is set when a character arrives with rx_err_i high. Bits 1 and 2 are cleared by a line status read unless set again in the same cycle.
- R10: A data read returns the oldest received character and removes it. A data read on an empty receive FIFO returns 0 and changes nothing.
- R11: tx_valid_o is high while the transmit FIFO is non-empty, and tx_data_o shows its oldest byte. tx_pop_i removes that byte; it may coincide with a host data write.
- R12: irq_o is high exactly while some enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects) |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| rx_push_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_err_i | input | 1 | Received character carries an error |
| tx_pop_i | input | 1 | Transmit shifter takes the head byte |
| tx_valid_o | output | 1 | Transmit FIFO non-empty |
| tx_data_o | output | 8 | Transmit FIFO head byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Every state change takes effect at the clock edge on which its strobe is sampled, and all outputs are combinational from state and the offset. A flag set, a flush or a pop is therefore visible on the outputs one cycle after the stimulus, and nothing later. The bench drives inputs on the falling edge and compares every output 2 ns later against a behavioural queue model, which is still in the pre-edge state. It then advances the model with the same inputs, so each result is checked in the first cycle it is due, and again in every cycle after.

// File: rtl/uart_fic_pkg.sv
package uart_fic_pkg;
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_IEN   = 3'd1;
  localparam logic [2:0] A_IDENT = 3'd2;
  localparam logic [2:0] A_LSTAT = 3'd5;

  typedef enum logic [2:0] {
    IID_NONE = 3'b000,
    IID_THRE = 3'b001,
    IID_RDA  = 3'b010,
    IID_RLS  = 3'b011
  } iid_e;

  function automatic int unsigned trig_depth(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/fic_fifo.sv
module fic_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  input  logic [CW-1:0] cap_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q >= cap_i);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign data_o  = mem_q[rptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_flush_empties_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
  assert_full_drops_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fic_irq_prio.sv
module fic_irq_prio
  import uart_fic_pkg::*;
(
  input  logic [2:0] en_i,
  input  logic       rls_i,
  input  logic       rda_i,
  input  logic       thre_i,
  output iid_e       iid_o,
  output logic       pend_o
);
  always_comb begin
    if (en_i[2] && rls_i)      iid_o = IID_RLS;
    else if (en_i[0] && rda_i) iid_o = IID_RDA;
    else if (en_i[1] && thre_i) iid_o = IID_THRE;
    else                       iid_o = IID_NONE;
  end
  assign pend_o = (iid_o != IID_NONE);
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
  import uart_fic_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       rx_push_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_err_i,
  input  logic       tx_pop_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic       fen_q, thre_q, oe_q, ce_q;
  logic [1:0] trig_q;
  logic [2:0] ier_q;

  logic wr_data, wr_ien, wr_fcr, rd_data, rd_ident, rd_lstat;
  assign wr_data  = reg_wr_i && (reg_addr_i == A_DATA);
  assign wr_ien   = reg_wr_i && (reg_addr_i == A_IEN);
  assign wr_fcr   = reg_wr_i && (reg_addr_i == A_IDENT);
  assign rd_data  = reg_rd_i && (reg_addr_i == A_DATA);
  assign rd_ident = reg_rd_i && (reg_addr_i == A_IDENT);
  assign rd_lstat = reg_rd_i && (reg_addr_i == A_LSTAT);

  logic fen_chg, rx_flush, tx_flush;
  assign fen_chg  = wr_fcr && (reg_wdata_i[0] != fen_q);
  assign rx_flush = wr_fcr && (reg_wdata_i[1] || fen_chg);
  assign tx_flush = wr_fcr && (reg_wdata_i[2] || fen_chg);

  logic [CW-1:0] cap, trig_lvl;
  assign cap = fen_q ? CW'(DEPTH) : CW'(1);

  always_comb begin
    int unsigned td;
    td = fen_q ? trig_depth(trig_q) : 1;
    if (td > DEPTH) td = DEPTH;
    trig_lvl = CW'(td);
  end

  logic [7:0]    rx_head, tx_head;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_full, rx_empty, tx_full, tx_empty;

  fic_fifo #(.DW(8), .DEPTH(DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i(rx_flush), .push_i(rx_push_i), .data_i(rx_data_i),
    .pop_i(rd_data), .cap_i(cap),
    .data_o(rx_head), .cnt_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  fic_fifo #(.DW(8), .DEPTH(DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i(tx_flush), .push_i(wr_data), .data_i(reg_wdata_i),
    .pop_i(tx_pop_i), .cap_i(cap),
    .data_o(tx_head), .cnt_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  logic rda, rls, pend;
  iid_e iid;
  assign rda = (rx_cnt >= trig_lvl);
  assign rls = oe_q | ce_q;

  fic_irq_prio i_prio (
    .en_i(ier_q), .rls_i(rls), .rda_i(rda), .thre_i(thre_q),
    .iid_o(iid), .pend_o(pend)
  );

  // THRE: set on drain-to-empty or on enabling while empty; set beats clear
  logic tx_to_empty, thre_set, thre_clr;
  assign tx_to_empty = !tx_empty &&
                       (tx_flush || (tx_pop_i && tx_cnt == CW'(1) && !(wr_data && !tx_full)));
  assign thre_set = tx_to_empty || (wr_ien && reg_wdata_i[1] && !ier_q[1] && tx_empty);
  assign thre_clr = wr_data || (rd_ident && iid == IID_THRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fen_q  <= 1'b0;
      trig_q <= '0;
      ier_q  <= '0;
      thre_q <= 1'b0;
      oe_q   <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      if (wr_fcr) begin
        fen_q  <= reg_wdata_i[0];
        trig_q <= reg_wdata_i[7:6];
      end
      if (wr_ien) ier_q <= reg_wdata_i[2:0];
      if (thre_set)      thre_q <= 1'b1;
      else if (thre_clr) thre_q <= 1'b0;
      if (rx_push_i && rx_full)     oe_q <= 1'b1;
      else if (rd_lstat)            oe_q <= 1'b0;
      if (rx_push_i && rx_err_i)    ce_q <= 1'b1;
      else if (rd_lstat)            ce_q <= 1'b0;
    end
  end

  logic [7:0] iir, lsr;
  assign iir = {fen_q, fen_q, 2'b00, iid, ~pend};
  assign lsr = {2'b00, tx_empty, 2'b00, ce_q, oe_q, ~rx_empty};

  always_comb begin
    case (reg_addr_i)
      A_DATA:  reg_rdata_o = rx_empty ? 8'h00 : rx_head;
      A_IEN:   reg_rdata_o = {5'b0, ier_q};
      A_IDENT: reg_rdata_o = iir;
      A_LSTAT: reg_rdata_o = lsr;
      default: reg_rdata_o = 8'h00;
    endcase
  end

  assign tx_valid_o = ~tx_empty;
  assign tx_data_o  = tx_head;
  assign irq_o      = pend;

  assert_overrun_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full) |=> oe_q);
  assert_rls_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_q[2] && rls) |-> (iid == IID_RLS));
  assert_thr_write_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !tx_full) |=> !thre_q);
  assert_data_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_full && !rx_flush) |=> !rx_empty);
  assert_rda_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ier_q[0]) |-> (iid != IID_RDA));
endmodule

// File: tb/test_uart_fifo_irq_ctrl.sv
module test_uart_fifo_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 0, reg_rd = 0, rx_push = 0, rx_err = 0, tx_pop = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, rx_data = 0;
  logic [7:0] reg_rdata, tx_data;
  logic       tx_valid, irq;

  always #5 clk = ~clk;

  uart_fifo_irq_ctrl i_uart_fifo_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_err_i(rx_err),
    .tx_pop_i(tx_pop), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .irq_o(irq)
  );

  // behavioural model
  logic [7:0] mrx[$], mtx[$];
  bit fen = 0, thre = 0, oe = 0, ce = 0;
  bit [1:0] trig = 0;
  bit [2:0] ier = 0;
  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1";

  function automatic int m_cap(); return fen ? 16 : 1; endfunction
  function automatic int m_trig();
    if (!fen) return 1;
    case (trig) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction
  function automatic bit [2:0] m_iid();
    if (ier[2] && (oe || ce)) return 3;
    if (ier[0] && mrx.size() >= m_trig()) return 2;
    if (ier[1] && thre) return 1;
    return 0;
  endfunction

  task automatic fail(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_bad++;
    $display("FAIL %s (%s) %s got %h expected %h at %0t", req, phase, what, got, exp, $time);
  endtask

  task automatic compare();
    logic [7:0] e;
    string req;
    bit [2:0] c;
    c = m_iid();
    case (reg_addr)
      3'd0: begin e = (mrx.size() > 0) ? mrx[0] : 8'h00; req = "R10"; end
      3'd1: begin e = {5'b0, ier}; req = "R6"; end
      3'd2: begin e = {fen, fen, 2'b00, c, (c == 0)}; req = "R7"; end
      3'd5: begin e = {2'b00, (mtx.size() == 0), 2'b00, ce, oe, (mrx.size() > 0)}; req = "R9"; end
      default: begin e = 8'h00; req = "R1"; end
    endcase
    n_vec++;
    if (reg_rdata !== e) fail(req, "reg_rdata", reg_rdata, e);
    if (irq !== (c != 0)) fail("R12", "irq_o", {7'b0, irq}, {7'b0, (c != 0)});
    if (tx_valid !== (mtx.size() > 0)) fail("R11", "tx_valid_o", {7'b0, tx_valid}, {7'b0, (mtx.size() > 0)});
    if (mtx.size() > 0 && tx_data !== mtx[0]) fail("R11", "tx_data_o", tx_data, mtx[0]);
  endtask

  task automatic step_model();
    int rn, tn, cap;
    bit [2:0] c;
    bit tset, tclr, chg;
    rn = mrx.size(); tn = mtx.size(); cap = m_cap(); c = m_iid();
    tset = 0; tclr = 0;
    if (reg_rd && reg_addr == 5) begin oe = 0; ce = 0; end
    if (reg_rd && reg_addr == 0 && rn > 0) void'(mrx.pop_front());
    if (rx_push) begin
      if (rn < cap) mrx.push_back(rx_data); else oe = 1;
      if (rx_err) ce = 1;
    end
    if (tx_pop && tn > 0) void'(mtx.pop_front());
    if (reg_wr && reg_addr == 0) begin
      if (tn < cap) mtx.push_back(reg_wdata);
      tclr = 1;
    end
    if (reg_rd && reg_addr == 2 && c == 1) tclr = 1;
    if (reg_wr && reg_addr == 1) begin
      if (reg_wdata[1] && !ier[1] && tn == 0) tset = 1;
      ier = reg_wdata[2:0];
    end
    if (reg_wr && reg_addr == 2) begin
      chg = (reg_wdata[0] != fen);
      if (reg_wdata[1] || chg) mrx.delete();
      if (reg_wdata[2] || chg) mtx.delete();
      fen = reg_wdata[0];
      trig = reg_wdata[7:6];
    end
    if (tn != 0 && mtx.size() == 0) tset = 1;
    if (tset) thre = 1; else if (tclr) thre = 0;
  endtask

  task automatic cyc();
    #2;
    compare();
    step_model();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(); reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a);
    reg_rd = 1; reg_addr = a; cyc(); reg_rd = 0;
  endtask
  task automatic rxin(input logic [7:0] d, input logic e);
    rx_push = 1; rx_data = d; rx_err = e; cyc(); rx_push = 0; rx_err = 0;
  endtask
  task automatic pop_tx();
    tx_pop = 1; cyc(); tx_pop = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state at every offset
    phase = "R1";
    reg_addr = 3'd2; idle(1);
    reg_addr = 3'd5; idle(1);
    reg_addr = 3'd1; idle(1);
    reg_addr = 3'd7; idle(1);
    reg_addr = 3'd0; idle(1);

    // R2: disabled mode holds one entry; overrun on second
    phase = "R2";
    rxin(8'hA1, 0); rxin(8'hA2, 0);
    reg_addr = 3'd5; idle(1);
    rd(3'd5); rd(3'd0); rd(3'd0);
    wr(3'd0, 8'h11); wr(3'd0, 8'h12); pop_tx();
    wr(3'd2, 8'h01); reg_addr = 3'd2; idle(1);

    // R3 / R10: 16-deep order, overrun on 17th, empty read gives 0
    phase = "R3";
    for (int i = 0; i < 17; i++) rxin(8'(8'h40 + i), 0);
    reg_addr = 3'd5; idle(1);
    phase = "R10";
    for (int i = 0; i < 17; i++) rd(3'd0);
    rd(3'd5);
    phase = "R3";
    for (int i = 0; i < 17; i++) wr(3'd0, 8'(8'h80 + i));
    for (int i = 0; i < 17; i++) pop_tx();

    // R5: each trigger depth, with rx-data interrupt enabled
    phase = "R5";
    wr(3'd1, 8'h01);
    for (int s = 0; s < 4; s++) begin
      wr(3'd2, {2'(s), 6'b000001});
      for (int i = 0; i < 15; i++) rxin(8'(i), 0);
      reg_addr = 3'd2;
      for (int i = 0; i < 15; i++) rd(3'd0);
    end

    // R4: selective flushes; control writes without reset bits keep data
    phase = "R4";
    for (int i = 0; i < 3; i++) rxin(8'(8'hC0 + i), 0);
    for (int i = 0; i < 5; i++) wr(3'd0, 8'(8'hD0 + i));
    wr(3'd2, 8'h01); reg_addr = 3'd5; idle(1);
    wr(3'd2, 8'h03); reg_addr = 3'd5; idle(1);
    for (int i = 0; i < 2; i++) rxin(8'(8'hE0 + i), 0);
    wr(3'd2, 8'h05); reg_addr = 3'd5; idle(1);
    wr(3'd0, 8'h77);
    wr(3'd2, 8'h07); reg_addr = 3'd5; idle(1);

    // R8: THRE set by enable/drain, cleared by IIR read and data write
    phase = "R8";
    wr(3'd1, 8'h00); wr(3'd1, 8'h02);
    reg_addr = 3'd2; idle(1);
    rd(3'd2); rd(3'd2);
    wr(3'd0, 8'h55); pop_tx();
    reg_addr = 3'd2; idle(1);
    wr(3'd0, 8'h56); reg_addr = 3'd2; idle(1);
    pop_tx();

    // R7: priority line status > rx data > THRE
    phase = "R7";
    wr(3'd1, 8'h07); wr(3'd2, 8'h01);
    rxin(8'h99, 1);
    reg_addr = 3'd2; idle(1);
    rd(3'd5); reg_addr = 3'd2; idle(1);
    rd(3'd0); reg_addr = 3'd2; idle(1);
    rd(3'd2); reg_addr = 3'd2; idle(1);

    // R6: sources pending but disabled
    phase = "R6";
    rxin(8'h01, 1);
    wr(3'd1, 8'h00); reg_addr = 3'd2; idle(1);
    wr(3'd1, 8'h04); rd(3'd5); rd(3'd0);

    // R11: pops concurrent with writes
    phase = "R11";
    wr(3'd1, 8'h02);
    wr(3'd0, 8'hF0);
    tx_pop = 1; wr(3'd0, 8'hF1); wr(3'd0, 8'hF2); tx_pop = 0;
    pop_tx(); pop_tx();

    // R2: enable toggle flushes both FIFOs; disabled mode concurrency
    phase = "R2";
    rxin(8'h31, 0); wr(3'd0, 8'h32);
    wr(3'd2, 8'h00); reg_addr = 3'd2; idle(1);
    wr(3'd0, 8'h33);
    tx_pop = 1; wr(3'd0, 8'h34); tx_pop = 0;
    wr(3'd2, 8'h01);

    // mixed traffic across all requirements (R12 irq compared every cycle)
    phase = "R12";
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      rx_push = ($urandom_range(0, 2) == 0);
      rx_data = 8'($urandom);
      rx_err  = ($urandom_range(0, 9) == 0);
      tx_pop  = ($urandom_range(0, 2) == 0);
      reg_addr = (k < 3) ? 3'd0 : (k < 5) ? 3'd2 : (k < 7) ? 3'd5 : 3'd1;
      reg_rd = ($urandom_range(0, 1) == 0);
      reg_wr = !reg_rd && ($urandom_range(0, 2) == 0);
      reg_wdata = 8'($urandom);
      if (reg_addr == 3'd2) reg_wdata[0] = ($urandom_range(0, 7) != 0);
      if (reg_addr == 3'd2 && $urandom_range(0, 3) != 0) reg_wdata[2:1] = 2'b00;
      cyc();
    end
    reg_rd = 0; reg_wr = 0; rx_push = 0; rx_err = 0; tx_pop = 0;
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule